// File: doc/BRIEF.md
# Low Pin Count Memory Write Target

This block is the peripheral end of a Low Pin Count bus, and it accepts only single-byte memory writes. On every rising clock edge it samples an active-low framing input and a 4-bit nibble bus. When it sees a valid start and a write cycle type, it collects a 32-bit address and one data byte over the following clocks. It then waits out the host's two turn-around clocks, takes over the nibble bus to report "ready", and hands the bus back to the host.

Bus ownership uses separate output-value and output-enable signals, so the pad-level tri-state buffer sits outside this block. When the target has reported ready, it presents the assembled address and byte together with a one-clock write strobe. Any clock on which the framing input is low restarts decoding. This lets the host abandon a cycle at any point.

Top module: `lpc_wr_target`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `bus_oe` and `wr_valid` are 0.
- R2: While `frame_n` is high and no cycle is in progress, the nibble bus is ignored: no cycle starts, `bus_oe` stays 0 and `wr_valid` stays 0.
- R3: On each clock with `frame_n` low, the sampled nibble replaces any earlier one as the start field. A cycle starts only if the nibble on the last low clock is 4'b0000.
- R4: The nibble on the clock after the start is accepted only when bits 3:2 equal 2'b01 and bit 1 equals 1, and bit 0 is ignored. Any other value returns the target to idle, and it does not drive the bus.
- R5: The next eight nibbles form the address with the most-significant nibble first: the first nibble is address bits 31:28 and the eighth is bits 3:0.
- R6: The next two nibbles form the byte with the low nibble first: the first nibble is data bits 3:0 and the second is bits 7:4.
- R7: `bus_oe` stays 0 through the fourteen clocks from start to the second host turn-around clock. On the fifteenth clock it is 1 with `bus_out` = 4'b0000 (ready).
- R8: On the sixteenth clock `bus_oe` is 1 with `bus_out` = 4'b1111. On the seventeenth clock `bus_oe` is 0.
- R9: `wr_valid` is high for exactly the one clock after the ready nibble. During that clock `wr_addr` and `wr_data` hold the address and byte of that cycle.
- R10: `frame_n` low during a cycle in progress abandons that cycle without a write strobe. If the nibble on that clock is 4'b0000, a new cycle starts from it.
- R11: A new start may follow directly after the seventeenth clock. Consecutive cycles each produce their own strobe with their own address and byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low cycle framing from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble the target presents when it owns the bus |
| bus_oe | output | 1 | High when the target drives the bus |
| wr_addr | output | 32 | Address of the last completed write |
| wr_data | output | 8 | Byte of the last completed write |
| wr_valid | output | 1 | One-clock strobe marking a completed write |

## Verification
The hardest cases to reach are those where the framing input is low over more than one clock. In one, an earlier nibble during the low time would start a cycle but a later one cancels it. In another, the host pulls framing low again in the middle of an address. The driver task takes an optional leading nibble, which is sent on an extra low-framing clock before the start nibble, so both orderings of start and non-start nibbles are produced. A separate sequence stops a cycle after three address nibbles and immediately issues a full write. The scoreboard must then see exactly one strobe, which carries the new cycle's values.

// File: rtl/lpc_wr_pkg.sv
package lpc_wr_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_ONES  = 4'b1111;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_TYPE,
        PH_ADDR,
        PH_DATA,
        PH_HOST_TA0,
        PH_HOST_TA1,
        PH_READY,
        PH_TGT_TA0,
        PH_TGT_TA1
    } phase_e;

    typedef struct packed {
        logic addr_shift;
        logic data_shift;
        logic commit;
    } dp_ctl_t;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] val;
    } drive_t;

    function automatic logic is_mem_write(input logic [NIB_W-1:0] n);
        return (n[3:2] == 2'b01) && n[1];
    endfunction

endpackage

// File: rtl/lpc_wr_fsm.sv
module lpc_wr_fsm
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_NIBS = 8,
    parameter int DATA_NIBS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] nib,
    output phase_e           phase,
    output dp_ctl_t          ctl
);

    localparam int MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!frame_n) begin
            phase_d = (nib == NIB_START) ? PH_TYPE : PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE:     phase_d = PH_IDLE;
                PH_TYPE: begin
                    phase_d = is_mem_write(nib) ? PH_ADDR : PH_IDLE;
                    cnt_d   = '0;
                end
                PH_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        phase_d = PH_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == DATA_LAST) begin
                        phase_d = PH_HOST_TA0;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HOST_TA0: phase_d = PH_HOST_TA1;
                PH_HOST_TA1: phase_d = PH_READY;
                PH_READY:    phase_d = PH_TGT_TA0;
                PH_TGT_TA0:  phase_d = PH_TGT_TA1;
                PH_TGT_TA1:  phase_d = PH_IDLE;
                default:     phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ctl.addr_shift = frame_n && (phase_q == PH_ADDR);
        ctl.data_shift = frame_n && (phase_q == PH_DATA);
        ctl.commit     = frame_n && (phase_q == PH_READY);
    end

    assign phase = phase_q;

endmodule

// File: rtl/lpc_wr_shift.sv
module lpc_wr_shift
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  nib,
    input  dp_ctl_t           ctl,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid
);

    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;

    // Address: first nibble ends up in the top bits.
    generate
        if (ADDR_W > NIB_W) begin : g_addr_multi
            always_ff @(posedge clk) begin
                if (rst)                 addr_sh <= '0;
                else if (ctl.addr_shift) addr_sh <= {addr_sh[ADDR_W-NIB_W-1:0], nib};
            end
        end else begin : g_addr_single
            always_ff @(posedge clk) begin
                if (rst)                 addr_sh <= '0;
                else if (ctl.addr_shift) addr_sh <= nib[ADDR_W-1:0];
            end
        end
    endgenerate

    // Data: first nibble ends up in the bottom bits.
    generate
        if (DATA_W > NIB_W) begin : g_data_multi
            always_ff @(posedge clk) begin
                if (rst)                 data_sh <= '0;
                else if (ctl.data_shift) data_sh <= {nib, data_sh[DATA_W-1:NIB_W]};
            end
        end else begin : g_data_single
            always_ff @(posedge clk) begin
                if (rst)                 data_sh <= '0;
                else if (ctl.data_shift) data_sh <= nib[DATA_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_valid <= 1'b0;
        end else begin
            wr_valid <= ctl.commit;
            if (ctl.commit) begin
                wr_addr <= addr_sh;
                wr_data <= data_sh;
            end
        end
    end

endmodule

// File: rtl/lpc_wr_drive.sv
module lpc_wr_drive
    import lpc_wr_pkg::*;
(
    input  phase_e phase,
    output drive_t drv
);

    always_comb begin
        unique case (phase)
            PH_READY:   drv = '{oe: 1'b1, val: NIB_READY};
            PH_TGT_TA0: drv = '{oe: 1'b1, val: NIB_ONES};
            default:    drv = '{oe: 1'b0, val: NIB_ONES};
        endcase
    end

endmodule

// File: rtl/lpc_wr_target.sv
module lpc_wr_target
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;

    phase_e  phase;
    dp_ctl_t ctl;
    drive_t  drv;

    lpc_wr_fsm #(
        .ADDR_NIBS(ADDR_NIBS),
        .DATA_NIBS(DATA_NIBS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .nib     (bus_in),
        .phase   (phase),
        .ctl     (ctl)
    );

    lpc_wr_shift #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .nib      (bus_in),
        .ctl      (ctl),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_valid (wr_valid)
    );

    lpc_wr_drive u_drive (
        .phase (phase),
        .drv   (drv)
    );

    assign bus_out = drv.val;
    assign bus_oe  = drv.oe;

endmodule

// File: rtl/lpc_wr_checker.sv
module lpc_wr_checker (
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       wr_valid
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bus_oe && !wr_valid));

    p_ready_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (bus_out == 4'b0000));

    p_ones_after_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && bus_out == 4'b0000 && frame_n) |=> (bus_oe && bus_out == 4'b1111));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && bus_out == 4'b1111 && frame_n) |=> !bus_oe);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    p_strobe_after_ready_r9: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(bus_oe && bus_out == 4'b0000 && frame_n));

endmodule

bind lpc_wr_target lpc_wr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .wr_valid (wr_valid)
);

// File: tb/lpc_wr_target_bench.sv
`timescale 1ns/1ps
module lpc_wr_target_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic [3:0]  bus_in;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_valid;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] a;
        logic [7:0]  d;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    lpc_wr_target u_lpc_wr_target (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_valid (wr_valid)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic fn, input logic [3:0] n);
        @(negedge clk);
        frame_n = fn;
        bus_in  = n;
    endtask

    // Monitor: every strobe must match the oldest expected write.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && wr_valid) begin
            if (sb.size() == 0) begin
                chk("R9/R10 unexpected strobe", 40'd1, 40'd0);
            end else begin
                e = sb.pop_front();
                chk("R5 address", {8'h0, wr_addr}, {8'h0, e.a});
                chk("R6 data", {32'h0, wr_data}, {32'h0, e.d});
            end
        end
    end

    task automatic run_write(input bit lead_on, input logic [3:0] lead,
                             input logic [3:0] st, input logic [3:0] ct,
                             input logic [31:0] a, input logic [7:0] d);
        bit ok;
        int oe_hits;
        int late_hits;
        ok = (st == 4'b0000) && (ct[3:2] == 2'b01) && ct[1];
        oe_hits = 0;
        late_hits = 0;
        if (lead_on) begin
            tick(1'b0, lead);
            oe_hits += int'(bus_oe);
        end
        tick(1'b0, st);
        oe_hits += int'(bus_oe);
        tick(1'b1, ct);
        oe_hits += int'(bus_oe);
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, a[31-4*i -: 4]);
            oe_hits += int'(bus_oe);
        end
        tick(1'b1, d[3:0]);
        oe_hits += int'(bus_oe);
        tick(1'b1, d[7:4]);
        oe_hits += int'(bus_oe);
        tick(1'b1, 4'hF);
        oe_hits += int'(bus_oe);
        tick(1'b1, 4'hF);
        oe_hits += int'(bus_oe);
        chk("R7 no drive before handoff", 40'(oe_hits), 40'd0);
        if (ok) begin
            sb.push_back('{a: a, d: d});
            tick(1'b1, 4'hF);
            chk("R7 ready nibble", {35'h0, bus_oe, bus_out}, {35'h0, 1'b1, 4'h0});
            tick(1'b1, 4'hF);
            chk("R8 ones nibble", {35'h0, bus_oe, bus_out}, {35'h0, 1'b1, 4'hF});
            chk("R9 strobe timing", {39'h0, wr_valid}, 40'd1);
            tick(1'b1, 4'hF);
            chk("R8 released", {39'h0, bus_oe}, 40'd0);
        end else begin
            for (int i = 0; i < 4; i++) begin
                tick(1'b1, 4'hF);
                late_hits += int'(bus_oe) + int'(wr_valid);
            end
            chk("R4/R3 rejected cycle silent", 40'(late_hits), 40'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int hits;
        rst = 1'b1;
        frame_n = 1'b1;
        bus_in = 4'hF;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {38'h0, bus_oe, wr_valid}, 40'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {38'h0, bus_oe, wr_valid}, 40'd0);

        // R2: zero nibbles and a full write pattern with framing high.
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 4'h0);
            hits += int'(bus_oe) + int'(wr_valid);
        end
        tick(1'b1, 4'h6);
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, 4'(i));
            hits += int'(bus_oe) + int'(wr_valid);
        end
        chk("R2 framing high ignored", 40'(hits), 40'd0);

        // R5 R6 R7 R8 R9: plain writes
        run_write(1'b0, 4'h0, 4'h0, 4'b0110, 32'h1234_5678, 8'hA5);
        run_write(1'b0, 4'h0, 4'h0, 4'b0111, 32'hFFFF_C001, 8'h3C); // R4 bit 0 ignored
        // R4: other cycle types rejected
        run_write(1'b0, 4'h0, 4'h0, 4'b0100, 32'hDEAD_BEEF, 8'h11);
        run_write(1'b0, 4'h0, 4'h0, 4'b1110, 32'h0BAD_F00D, 8'h22);
        run_write(1'b0, 4'h0, 4'h0, 4'b0010, 32'h5555_AAAA, 8'h33);
        // R3: last low-framing nibble decides
        run_write(1'b1, 4'h3, 4'h0, 4'b0110, 32'h8000_0001, 8'h7E);
        run_write(1'b1, 4'h0, 4'h5, 4'b0110, 32'h0000_FFFF, 8'h44);

        // R10: abort in the address, restart from the abort clock
        tick(1'b0, 4'h0);
        tick(1'b1, 4'b0110);
        tick(1'b1, 4'h9);
        tick(1'b1, 4'h8);
        tick(1'b1, 4'h7);
        run_write(1'b0, 4'h0, 4'h0, 4'b0110, 32'hCAFE_0042, 8'h5A);
        // R10: abort with a non-start nibble leaves the target idle
        tick(1'b0, 4'h0);
        tick(1'b1, 4'b0110);
        tick(1'b1, 4'hA);
        tick(1'b0, 4'h7);
        hits = 0;
        for (int i = 0; i < 18; i++) begin
            tick(1'b1, 4'h0);
            hits += int'(bus_oe) + int'(wr_valid);
        end
        chk("R10 aborted cycle silent", 40'(hits), 40'd0);

        // R11: back-to-back writes
        run_write(1'b0, 4'h0, 4'h0, 4'b0110, 32'h0000_0000, 8'h00);
        run_write(1'b0, 4'h0, 4'h0, 4'b0111, 32'hFFFF_FFFF, 8'hFF);
        run_write(1'b0, 4'h0, 4'h0, 4'b0110, 32'h0F0F_1E2D, 8'h96);

        repeat (4) tick(1'b1, 4'hF);
        chk("R11 all strobes seen", 40'(sb.size()), 40'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule